// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

This block drives a parallel RGB panel. It produces horizontal sync, vertical sync, data-enable, a pixel clock and a matching one-cycle pixel clock-enable. It also gives the current active column and row so that a downstream pixel fetch can follow the scan, and a frame-start pulse. Every timing field is given as its count minus one on plain input ports. The pixel period is `pix_div_m1 + 1` system clocks. A line is made of four segments in this order: sync, back porch, active, front porch. A frame uses the same four segments, counted in lines.

Two state machines control the block. The control FSM has three states. `CTL_IDLE` holds the outputs inactive. It moves to `CTL_RUN` on the first divider tick that sees `video_en` high. `CTL_RUN` moves to `CTL_DRAIN` when `video_en` falls, or goes straight to `CTL_IDLE` if that happens on the last pixel of a frame. `CTL_DRAIN` returns to `CTL_RUN` if `video_en` comes back. Otherwise it moves to `CTL_IDLE` at the end of the frame. Each axis sequencer walks the states `SEG_SYNC`, `SEG_BACK`, `SEG_ACTIVE` and `SEG_FRONT`, in that order and cyclically. It leaves a state when the position counter reaches the minus-one limit for that state. The horizontal axis steps on every pixel tick. The vertical axis steps on the last pixel of each line.

Each of hsync, vsync and data-enable has its own inversion input. A launch-edge select inverts the pixel clock.

Top module: `rgb_panel_timing`

## Requirements
- R1: After reset, with `video_en` low, `hsync`, `vsync` and `de` sit at their inactive levels (equal to their inversion inputs), `pclk` equals `pclk_fall`, and `pix_ce`, `frame_start`, `pix_col` and `pix_row` are 0.
- R2: While the generator runs, `pix_ce` is high for exactly one cycle in every `pix_div_m1+1` cycles, on the first cycle of each pixel period.
- R3: Active hsync lasts `h_sync_m1+1` pixel periods, and hsync repeats every Htot = (h_sync_m1+1)+(h_back_m1+1)+(h_act_m1+1)+(h_front_m1+1) pixel periods.
- R4: Within a line the segment order is sync, back porch, active, front porch. Within a frame the same order applies in lines.
- R5: Active `de` is asserted only when both the horizontal and vertical positions lie in their active segments. That gives `h_act_m1+1` pixels per line on `v_act_m1+1` lines.
- R6: Active vsync lasts `v_sync_m1+1` lines and starts together with the line's hsync. Frames repeat every Htot*Vtot pixel periods, where Vtot is the vertical sum formed like Htot.
- R7: While `de` is active, `pix_col` counts 0 to `h_act_m1` across the line and `pix_row` gives the index of the active line, starting at 0.
- R8: `hsync_inv`, `vsync_inv` and `de_inv` each invert only their own output (1 = active-low). This applies both while running and while idle.
- R9: While running, the active-sense pixel clock is high for the first ceil(N/2) cycles of each N-cycle pixel period and low for the rest. `pclk_fall` = 1 inverts it. When idle the active-sense level is 0.
- R10: `frame_start` is a one-cycle pulse on the first cycle of the first pixel of each frame. It coincides with `pix_ce` and with active hsync and vsync.
- R11: Raising `video_en` starts a frame within N+2 cycles. Clearing it lets the current frame finish all Htot*Vtot pixels. After that no further `pix_ce` or `frame_start` occurs and the outputs return to inactive levels.
- R12: If `video_en` is cleared and then set again before the frame ends, timing continues without a gap, and the next frame starts exactly one frame period after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Global video enable |
| pix_div_m1 | input | DIV_W | Pixel period minus one, in system clocks |
| h_sync_m1 | input | PORCH_W | Hsync width minus one, in pixels |
| h_back_m1 | input | PORCH_W | Horizontal back porch minus one |
| h_act_m1 | input | ACT_W | Active columns minus one |
| h_front_m1 | input | PORCH_W | Horizontal front porch minus one |
| v_sync_m1 | input | PORCH_W | Vsync width minus one, in lines |
| v_back_m1 | input | PORCH_W | Vertical back porch minus one |
| v_act_m1 | input | ACT_W | Active rows minus one |
| v_front_m1 | input | PORCH_W | Vertical front porch minus one |
| hsync_inv | input | 1 | Invert hsync |
| vsync_inv | input | 1 | Invert vsync |
| de_inv | input | 1 | Invert data enable |
| pclk_fall | input | 1 | Launch data on the falling pixel-clock edge (inverts pclk) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_ce | output | 1 | Pixel clock-enable, one cycle per pixel |
| pclk | output | 1 | Divided pixel clock |
| frame_start | output | 1 | First-pixel-of-frame pulse |
| pix_col | output | ACT_W | Active column index |
| pix_row | output | ACT_W | Active row index |

## Verification
The checks assume that every timing field and every inversion input is held steady while the generator runs, and changes only in the idle state. Under that assumption the segment-range and data-enable-outside-sync checks hold. The bench honours this by loading each configuration from its table only after the previous frame has fully drained. It changes nothing but `video_en` while the scan is active. The stimulus vectors cover divider ratios of 1, 2, 3 and 5 and one-wide porches, so the one-cycle and wrap cases of every segment are exercised.

// File: rtl/tg_pkg.sv
package tg_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_e;
endpackage

// File: rtl/tg_clk_div.sv
module tg_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             tick,
    output logic [DIV_W-1:0] phase,
    output logic             first_half
);
    localparam int HW = DIV_W + 1;

    logic [HW-1:0] half_w;

    assign tick       = (phase >= ratio_m1);
    assign half_w     = ({1'b0, ratio_m1} + HW'(2)) >> 1;
    assign first_half = ({1'b0, phase} < half_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio_m1 != '0) |=> (!tick || ratio_m1 == '0));
endmodule

// File: rtl/tg_axis_seq.sv
module tg_axis_seq
    import tg_pkg::*;
#(
    parameter int SW = 8,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [SW-1:0] sync_m1,
    input  logic [SW-1:0] back_m1,
    input  logic [AW-1:0] act_m1,
    input  logic [SW-1:0] front_m1,
    output seg_e          seg,
    output logic [((SW > AW) ? SW : AW)-1:0] pos,
    output logic          last
);
    localparam int CW = (SW > AW) ? SW : AW;

    logic [CW-1:0] limit;
    seg_e          seg_nx;

    always_comb begin
        unique case (seg)
            SEG_SYNC:   limit = CW'(sync_m1);
            SEG_BACK:   limit = CW'(back_m1);
            SEG_ACTIVE: limit = CW'(act_m1);
            SEG_FRONT:  limit = CW'(front_m1);
        endcase
    end

    always_comb begin
        unique case (seg)
            SEG_SYNC:   seg_nx = SEG_BACK;
            SEG_BACK:   seg_nx = SEG_ACTIVE;
            SEG_ACTIVE: seg_nx = SEG_FRONT;
            SEG_FRONT:  seg_nx = SEG_SYNC;
        endcase
    end

    assign last = (seg == SEG_FRONT) && (pos == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg <= SEG_SYNC;
            pos <= '0;
        end else if (clr) begin
            seg <= SEG_SYNC;
            pos <= '0;
        end else if (step) begin
            if (pos == limit) begin
                pos <= '0;
                seg <= seg_nx;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (pos <= limit));

    // R4
    seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && pos == limit) |=> (seg == seg_e'($past(seg) + 2'd1)));
endmodule

// File: rtl/tg_ctl_fsm.sv
module tg_ctl_fsm
    import tg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic video_en,
    input  logic tick,
    input  logic frame_end,
    output ctl_e st,
    output logic running
);
    ctl_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CTL_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CTL_IDLE:  if (video_en && tick) st_nx = CTL_RUN;
            CTL_RUN:   if (!video_en)        st_nx = frame_end ? CTL_IDLE : CTL_DRAIN;
            CTL_DRAIN: if (video_en)         st_nx = CTL_RUN;
                       else if (frame_end)   st_nx = CTL_IDLE;
            default:                         st_nx = CTL_IDLE;
        endcase
    end

    assign running = (st != CTL_IDLE);

    // R11
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CTL_DRAIN && !video_en && frame_end) |=> (st == CTL_IDLE));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CTL_IDLE && !video_en) |=> (st == CTL_IDLE));
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
    import tg_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PORCH_W = 8,
    parameter int ACT_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               video_en,
    input  logic [DIV_W-1:0]   pix_div_m1,
    input  logic [PORCH_W-1:0] h_sync_m1,
    input  logic [PORCH_W-1:0] h_back_m1,
    input  logic [ACT_W-1:0]   h_act_m1,
    input  logic [PORCH_W-1:0] h_front_m1,
    input  logic [PORCH_W-1:0] v_sync_m1,
    input  logic [PORCH_W-1:0] v_back_m1,
    input  logic [ACT_W-1:0]   v_act_m1,
    input  logic [PORCH_W-1:0] v_front_m1,
    input  logic               hsync_inv,
    input  logic               vsync_inv,
    input  logic               de_inv,
    input  logic               pclk_fall,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               pix_ce,
    output logic               pclk,
    output logic               frame_start,
    output logic [ACT_W-1:0]   pix_col,
    output logic [ACT_W-1:0]   pix_row
);
    localparam int CW = (PORCH_W > ACT_W) ? PORCH_W : ACT_W;

    logic             tick, first_half, running;
    logic [DIV_W-1:0] dphase;
    ctl_e             st;
    seg_e             h_seg, v_seg;
    logic [CW-1:0]    h_pos, v_pos;
    logic             h_last, v_last;
    logic             step_h, step_v, frame_end;

    logic hs_d, vs_d, de_d, ce_d, pc_d, fs_d;
    logic hs_q, vs_q, de_q, pc_q;
    logic [ACT_W-1:0] col_d, row_d;

    tg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .ratio_m1(pix_div_m1),
        .tick(tick), .phase(dphase), .first_half(first_half)
    );

    tg_ctl_fsm u_ctl (
        .clk(clk), .rst_n(rst_n), .video_en(video_en), .tick(tick),
        .frame_end(frame_end), .st(st), .running(running)
    );

    assign step_h    = tick && running;
    assign step_v    = step_h && h_last;
    assign frame_end = step_v && v_last;

    tg_axis_seq #(.SW(PORCH_W), .AW(ACT_W)) u_hax (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(step_h),
        .sync_m1(h_sync_m1), .back_m1(h_back_m1), .act_m1(h_act_m1),
        .front_m1(h_front_m1), .seg(h_seg), .pos(h_pos), .last(h_last)
    );

    tg_axis_seq #(.SW(PORCH_W), .AW(ACT_W)) u_vax (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(step_v),
        .sync_m1(v_sync_m1), .back_m1(v_back_m1), .act_m1(v_act_m1),
        .front_m1(v_front_m1), .seg(v_seg), .pos(v_pos), .last(v_last)
    );

    // Decode of the current scan position (active-sense)
    always_comb begin
        hs_d  = running && (h_seg == SEG_SYNC);
        vs_d  = running && (v_seg == SEG_SYNC);
        de_d  = running && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
        ce_d  = running && (dphase == '0);
        pc_d  = running && first_half;
        fs_d  = ce_d && (h_seg == SEG_SYNC) && (h_pos == '0)
                     && (v_seg == SEG_SYNC) && (v_pos == '0);
        col_d = de_d ? ACT_W'(h_pos) : '0;
        row_d = de_d ? ACT_W'(v_pos) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q        <= 1'b0;
            vs_q        <= 1'b0;
            de_q        <= 1'b0;
            pc_q        <= 1'b0;
            pix_ce      <= 1'b0;
            frame_start <= 1'b0;
            pix_col     <= '0;
            pix_row     <= '0;
        end else begin
            hs_q        <= hs_d;
            vs_q        <= vs_d;
            de_q        <= de_d;
            pc_q        <= pc_d;
            pix_ce      <= ce_d;
            frame_start <= fs_d;
            pix_col     <= col_d;
            pix_row     <= row_d;
        end
    end

    assign hsync = hs_q ^ hsync_inv;
    assign vsync = vs_q ^ vsync_inv;
    assign de    = de_q ^ de_inv;
    assign pclk  = pc_q ^ pclk_fall;

    // R5
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_q |-> (!hs_q && !vs_q));

    // R10
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R10
    fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pix_ce && hs_q && vs_q));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CTL_IDLE && $past(st) == CTL_IDLE) |-> (!pix_ce && !frame_start && !de_q));
endmodule

// File: tb/rgb_panel_timing_test.sv
module rgb_panel_timing_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic video_en = 1'b0;
    logic [7:0]  pix_div_m1 = '0, h_sync_m1 = '0, h_back_m1 = '0, h_front_m1 = '0;
    logic [7:0]  v_sync_m1 = '0, v_back_m1 = '0, v_front_m1 = '0;
    logic [10:0] h_act_m1 = '0, v_act_m1 = '0;
    logic hsync_inv = 1'b0, vsync_inv = 1'b0, de_inv = 1'b0, pclk_fall = 1'b0;
    logic hsync, vsync, de, pix_ce, pclk, frame_start;
    logic [10:0] pix_col, pix_row;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rgb_panel_timing uut (
        .clk(clk), .rst_n(rst_n), .video_en(video_en), .pix_div_m1(pix_div_m1),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1),
        .h_front_m1(h_front_m1), .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
        .v_act_m1(v_act_m1), .v_front_m1(v_front_m1), .hsync_inv(hsync_inv),
        .vsync_inv(vsync_inv), .de_inv(de_inv), .pclk_fall(pclk_fall),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_ce(pix_ce), .pclk(pclk),
        .frame_start(frame_start), .pix_col(pix_col), .pix_row(pix_row)
    );

    typedef struct packed {
        logic [7:0]  div, hs, hb, hf, vs, vb, vf;
        logic [10:0] ha, va;
        logic        ih, iv, id, fl;
        logic [19:0] frame;
    } vec_t;

    // stimulus + expected frame length in system cycles
    localparam vec_t VECS [4] = '{
        '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 11'd3, 11'd1, 1'b0, 1'b0, 1'b0, 1'b0, 20'd35},
        '{8'd2, 8'd1, 8'd2, 8'd1, 8'd0, 8'd1, 8'd0, 11'd7, 11'd3, 1'b1, 1'b0, 1'b1, 1'b1, 20'd360},
        '{8'd1, 8'd2, 8'd0, 8'd3, 8'd1, 8'd0, 8'd1, 11'd4, 11'd2, 1'b0, 1'b1, 1'b0, 1'b0, 20'd208},
        '{8'd4, 8'd0, 8'd1, 8'd2, 8'd2, 8'd1, 8'd0, 11'd2, 11'd1, 1'b1, 1'b1, 1'b1, 1'b1, 20'd360}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_levels(input vec_t v, input string req);
        chk(hsync == v.ih && vsync == v.iv && de == v.id, {req, " sync/de idle levels"},
            {hsync, vsync, de}, {v.ih, v.iv, v.id});
        chk(pclk == v.fl && !pix_ce && !frame_start, {req, " pclk/pix_ce idle"},
            {pclk, pix_ce, frame_start}, {v.fl, 2'b00});
    endtask

    task automatic run_vec(input vec_t v, input bit reenable);
        int n, hs_n, hstart, htot, vs_n, vstart, vtot, w, pce, fsn;
        int e_hs, e_vs, e_de, e_pos, e_ce, e_pc, e_fs;
        n      = int'(v.div) + 1;
        hs_n   = int'(v.hs) + 1;
        hstart = hs_n + int'(v.hb) + 1;
        htot   = hstart + int'(v.ha) + 1 + int'(v.hf) + 1;
        vs_n   = int'(v.vs) + 1;
        vstart = vs_n + int'(v.vb) + 1;
        vtot   = vstart + int'(v.va) + 1 + int'(v.vf) + 1;
        pix_div_m1 = v.div; h_sync_m1 = v.hs; h_back_m1 = v.hb; h_act_m1 = v.ha;
        h_front_m1 = v.hf; v_sync_m1 = v.vs; v_back_m1 = v.vb; v_act_m1 = v.va;
        v_front_m1 = v.vf; hsync_inv = v.ih; vsync_inv = v.iv; de_inv = v.id;
        pclk_fall = v.fl;
        @(negedge clk);
        // R8: inversion bits alone set the idle levels
        idle_levels(v, "R8");
        chk(n * htot * vtot == int'(v.frame), "R6 table frame length", n * htot * vtot, int'(v.frame));
        video_en = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!frame_start && w < 100);
        chk(frame_start && w <= n + 2, "R11 start latency", w, n + 1);
        e_hs = 0; e_vs = 0; e_de = 0; e_pos = 0; e_ce = 0; e_pc = 0; e_fs = 0;
        for (int c = 0; c < int'(v.frame); c++) begin
            int px, p, ln, k;
            bit ex_de;
            px = c / n; p = px % htot; ln = px / htot; k = c % n;
            ex_de = (p >= hstart) && (p < hstart + int'(v.ha) + 1) &&
                    (ln >= vstart) && (ln < vstart + int'(v.va) + 1);
            if ((hsync ^ v.ih) != (p < hs_n)) e_hs++;
            if ((vsync ^ v.iv) != (ln < vs_n)) e_vs++;
            if ((de ^ v.id) != ex_de) e_de++;
            if (ex_de && (int'(pix_col) != p - hstart || int'(pix_row) != ln - vstart)) e_pos++;
            if (pix_ce != (k == 0)) e_ce++;
            if ((pclk ^ v.fl) != (k < (n + 1) / 2)) e_pc++;
            if (frame_start != (c == 0)) e_fs++;
            if (reenable && c == int'(v.frame) / 2) video_en = 1'b0;
            if (reenable && c == int'(v.frame) / 2 + 10) video_en = 1'b1;
            @(negedge clk);
        end
        chk(e_hs == 0, "R3 hsync width and line period", e_hs, 0);
        chk(e_vs == 0, "R6 vsync width in lines", e_vs, 0);
        chk(e_de == 0, "R5 de window (R4 segment order)", e_de, 0);
        chk(e_pos == 0, "R7 column/row index", e_pos, 0);
        chk(e_ce == 0, "R2 pix_ce cadence", e_ce, 0);
        chk(e_pc == 0, "R9 pclk shape and edge select", e_pc, 0);
        chk(e_fs == 0, "R10 single frame_start", e_fs, 0);
        chk(frame_start == 1'b1, reenable ? "R12 cadence after re-enable" : "R6 frame period",
            frame_start, 1);
        // drain: current frame must complete, then stop
        video_en = 1'b0;
        pce = 0; fsn = 0;
        for (int c = 0; c < int'(v.frame) + 20; c++) begin
            if (pix_ce) pce++;
            if (frame_start) fsn++;
            @(negedge clk);
        end
        chk(pce == htot * vtot, "R11 drained frame pixel count", pce, htot * vtot);
        chk(fsn == 1, "R11 no frame_start after disable", fsn, 1);
        idle_levels(v, "R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R11: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk(!hsync && !vsync && !de && !pix_ce && !frame_start, "R1 outputs in reset",
            {hsync, vsync, de, pix_ce, frame_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!hsync && !vsync && !de && !pix_ce && !frame_start && !pclk, "R1 idle after reset",
            {hsync, vsync, de, pix_ce, frame_start, pclk}, 0);
        chk(pix_col == '0 && pix_row == '0, "R1 index outputs zero", int'(pix_col), 0);
        for (int i = 0; i < 4; i++) run_vec(VECS[i], 1'b0);
        // R12: brief disable inside a frame
        run_vec(VECS[1], 1'b1);
        run_vec(VECS[0], 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule